// File: doc/BRIEF.md
# Serial Port with Mode-Dependent Completion Flags

This block is a byte-wide serial transceiver. It sends and receives 8-bit data in one of two modes. In shift mode the data moves LSB first, one bit per bit time, and a shift clock is driven beside it. In framed mode the data travels as an asynchronous frame: one low start bit, eight data bits LSB first, and one high stop bit. The line idles high. A bit time is `OVS` pulses of the `tick_i` enable, which comes from a baud source outside the block.

Two completion flags report progress. The transmit flag and the receive flag each rise at a fixed point in the frame, and that point depends on the mode. Both flags stay set until software pulses the matching clear strobe. In framed mode, a filter input can hold the receive flag down for a frame whose stop bit arrived low. This suits a multi-drop link on which only frames that pass the filter should wake the host.

Top module: `serial_port_core`

## Requirements
- R1: While reset is high and just after it, `txd_o` = 1, `sclk_o` = 1, `ti_o` = 0, `ri_o` = 0 and `rx_data_o` = 0.
- R2: In framed mode (`mode_i` = 1), a load while idle sends a low start bit, then `tx_data_i` bit 0 through bit 7, then a high stop bit. Each bit lasts `OVS` ticks, and the start bit appears on `txd_o` in the cycle after the load. At all other times the line rests high.
- R3: In framed mode, `ti_o` rises on the same clock edge on which `txd_o` enters the stop bit. That edge is the 9*`OVS`-th tick after the load edge.
- R4: In shift mode (`mode_i` = 0), a load sends bits 0 to 7 on `txd_o`, `OVS` ticks each. `ti_o` rises at the end of the eighth bit, which is the 8*`OVS`-th tick after the load edge. At that edge `txd_o` returns high.
- R5: A `tx_load_i` pulse while a transmission is running is ignored. The frame on the line and the timing of `ti_o` stay exactly as they were for the first byte.
- R6: In framed mode, the receive line passes through a two-stage synchronizer. A frame starts on the first tick on which the synchronized line is low. Each bit is sampled `OVS`/2 ticks into its bit time, counted from that start tick. `ri_o` rises and `rx_data_o` takes the byte at the stop-bit sample, which is 9*`OVS`+`OVS`/2 ticks after the start tick.
- R7: In framed mode, a low pulse that is gone before the mid-point sample of the start bit is discarded. `ri_o` does not rise.
- R8: In framed mode with `sm2_i` = 1, a frame whose stop bit samples low leaves `ri_o` clear and `rx_data_o` unchanged. With `sm2_i` = 0, the same frame sets `ri_o` and delivers its byte.
- R9: In shift mode, reception starts when `ren_i` = 1 while `ri_o` = 0 and the receiver is idle. The line is sampled at the end of each bit time, and `ri_o` rises at the end of the eighth bit time, 8*`OVS` ticks after the start.
- R10: Neither flag clears itself. A flag stays set until its clear strobe is pulsed, and it reads 0 on the next cycle. A set event in the same cycle as the clear wins.
- R11: During a shift-mode transfer, `sclk_o` is low for the first `OVS`/2 ticks of each bit time and high for the rest. While no shift-mode transfer runs, `sclk_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Bit-time sub-tick enable, `OVS` per bit |
| mode_i | input | 1 | 0 = shift mode, 1 = framed mode |
| sm2_i | input | 1 | Receive filter: suppress frames whose stop bit samples low |
| ren_i | input | 1 | Shift-mode receive enable |
| tx_load_i | input | 1 | Load strobe for the transmit byte |
| tx_data_i | input | DATA_W | Byte to transmit |
| rxd_i | input | 1 | Serial receive line |
| ti_clr_i | input | 1 | Clear strobe for the transmit flag |
| ri_clr_i | input | 1 | Clear strobe for the receive flag |
| txd_o | output | 1 | Serial transmit line |
| sclk_o | output | 1 | Shift clock for shift mode |
| rx_data_o | output | DATA_W | Last accepted received byte |
| ti_o | output | 1 | Transmit completion flag |
| ri_o | output | 1 | Receive completion flag |

## Verification
With the tick held high, every result is due a fixed number of edges after the load edge:
- Each transmitted bit is valid from edge k*`OVS`.
- `ti_o` rises at edge 9*`OVS` in framed mode and at edge 8*`OVS` in shift mode.
- In loopback, `ri_o` rises at edge 3+9*`OVS`+`OVS`/2 in framed mode: two synchronizer stages plus the detect tick. In shift mode it rises at edge 8*`OVS`.

The timed driver counts falling edges from the load. It samples line bits at mid-bit, samples the flag one edge before and exactly at its due edge, and compares the cycle the scoreboard monitor recorded for `ri_o` with the expected offset. The runs with a slower tick, and the hand-driven frames, check only data and flag presence, not exact cycles.

// File: rtl/serport_pkg.sv
package serport_pkg;
  typedef enum logic {
    MODE_SHIFT  = 1'b0,
    MODE_FRAMED = 1'b1
  } sp_mode_e;
endpackage

// File: rtl/serport_flag.sv
// Sticky completion flag: set wins over clear.
module serport_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/serport_tx.sv
module serport_tx
  import serport_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  sp_mode_e          mode_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              txd_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              sclk_low_o
);
  localparam int PW = $clog2(OVS);
  localparam int BW = $clog2(DATA_W + 2);
  localparam logic [PW-1:0] PH_LAST  = PW'(OVS - 1);
  localparam logic [PW-1:0] PH_HALF  = PW'(OVS / 2);
  localparam logic [BW-1:0] IDX_LSTD = BW'(DATA_W - 1);
  localparam logic [BW-1:0] IDX_DEND = BW'(DATA_W);
  localparam logic [BW-1:0] IDX_STOP = BW'(DATA_W + 1);

  logic              busy;
  sp_mode_e          mode_q;
  logic [DATA_W-1:0] shreg;
  logic [BW-1:0]     bidx;
  logic [PW-1:0]     phase;
  logic              txd;
  logic              bit_end;

  assign bit_end    = busy && tick_i && (phase == PH_LAST);
  assign done_o     = bit_end &&
                      (((mode_q == MODE_SHIFT)  && (bidx == IDX_LSTD)) ||
                       ((mode_q == MODE_FRAMED) && (bidx == IDX_DEND)));
  assign sclk_low_o = busy && (mode_q == MODE_SHIFT) && (phase < PH_HALF);
  assign txd_o      = txd;
  assign busy_o     = busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      mode_q <= MODE_FRAMED;
      shreg  <= '0;
      bidx   <= '0;
      phase  <= '0;
      txd    <= 1'b1;
    end else if (!busy) begin
      if (load_i) begin
        busy   <= 1'b1;
        mode_q <= mode_i;
        shreg  <= data_i;
        bidx   <= '0;
        phase  <= '0;
        txd    <= (mode_i == MODE_FRAMED) ? 1'b0 : data_i[0];
      end
    end else if (tick_i) begin
      if (phase == PH_LAST) begin
        phase <= '0;
        bidx  <= bidx + BW'(1);
        if (mode_q == MODE_SHIFT) begin
          if (bidx == IDX_LSTD) begin
            busy <= 1'b0;
            txd  <= 1'b1;
          end else begin
            txd   <= shreg[1];
            shreg <= shreg >> 1;
          end
        end else begin
          if (bidx == '0) begin
            txd <= shreg[0];
          end else if (bidx < IDX_DEND) begin
            txd   <= shreg[1];
            shreg <= shreg >> 1;
          end else if (bidx == IDX_DEND) begin
            txd <= 1'b1;
          end else if (bidx == IDX_STOP) begin
            busy <= 1'b0;
          end
        end
      end else begin
        phase <= phase + PW'(1);
      end
    end
  end
endmodule

// File: rtl/serport_rx.sv
module serport_rx
  import serport_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  sp_mode_e          mode_i,
  input  logic              ren_i,
  input  logic              hold_i,
  input  logic              sm2_i,
  input  logic              rxd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              done_o,
  output logic              frame_end_o,
  output logic              line_o,
  output logic              busy_o,
  output sp_mode_e          mode_o,
  output logic              sclk_low_o
);
  localparam int PW = $clog2(OVS);
  localparam int BW = $clog2(DATA_W + 2);
  localparam logic [PW-1:0] PH_LAST  = PW'(OVS - 1);
  localparam logic [PW-1:0] PH_HALF  = PW'(OVS / 2);
  localparam logic [BW-1:0] IDX_LSTD = BW'(DATA_W - 1);
  localparam logic [BW-1:0] IDX_STOP = BW'(DATA_W + 1);

  logic              s1, s2;
  logic              busy;
  sp_mode_e          mode_q;
  logic [BW-1:0]     bidx;
  logic [PW-1:0]     phase;
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] data_q;
  logic              sample_pt;

  assign sample_pt   = busy && tick_i &&
                       (((mode_q == MODE_FRAMED) && (phase == PH_HALF)) ||
                        ((mode_q == MODE_SHIFT)  && (phase == PH_LAST)));
  assign frame_end_o = sample_pt &&
                       (((mode_q == MODE_FRAMED) && (bidx == IDX_STOP)) ||
                        ((mode_q == MODE_SHIFT)  && (bidx == IDX_LSTD)));
  assign done_o      = frame_end_o && ((mode_q == MODE_SHIFT) || !sm2_i || s2);
  assign line_o      = s2;
  assign busy_o      = busy;
  assign mode_o      = mode_q;
  assign data_o      = data_q;
  assign sclk_low_o  = busy && (mode_q == MODE_SHIFT) && (phase < PH_HALF);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rxd_i;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      mode_q <= MODE_FRAMED;
      bidx   <= '0;
      phase  <= '0;
      shreg  <= '0;
      data_q <= '0;
    end else if (!busy) begin
      if ((mode_i == MODE_FRAMED) && tick_i && !s2) begin
        busy   <= 1'b1;
        mode_q <= MODE_FRAMED;
        phase  <= PW'(1);
        bidx   <= '0;
      end else if ((mode_i == MODE_SHIFT) && ren_i && !hold_i) begin
        busy   <= 1'b1;
        mode_q <= MODE_SHIFT;
        phase  <= '0;
        bidx   <= '0;
      end
    end else if (tick_i) begin
      phase <= (phase == PH_LAST) ? '0 : phase + PW'(1);
      if ((mode_q == MODE_FRAMED) && (phase == PH_LAST))
        bidx <= bidx + BW'(1);
      if (sample_pt) begin
        if (frame_end_o) begin
          busy <= 1'b0;
          if (done_o)
            data_q <= (mode_q == MODE_SHIFT) ? {s2, shreg[DATA_W-1:1]} : shreg;
        end else if ((mode_q == MODE_FRAMED) && (bidx == '0)) begin
          if (s2) busy <= 1'b0;
        end else begin
          shreg <= {s2, shreg[DATA_W-1:1]};
          if (mode_q == MODE_SHIFT) bidx <= bidx + BW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/serial_port_core.sv
module serial_port_core
  import serport_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              mode_i,
  input  logic              sm2_i,
  input  logic              ren_i,
  input  logic              tx_load_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              rxd_i,
  input  logic              ti_clr_i,
  input  logic              ri_clr_i,
  output logic              txd_o,
  output logic              sclk_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              ti_o,
  output logic              ri_o
);
  sp_mode_e mode_sel;
  sp_mode_e rx_mode;
  logic     tx_busy, tx_done, tx_sclk_low;
  logic     rx_busy, rx_done, rx_frame_end, rx_line, rx_sclk_low;

  assign mode_sel = sp_mode_e'(mode_i);
  assign sclk_o   = !(tx_sclk_low || rx_sclk_low);

  serport_tx #(.OVS(OVS), .DATA_W(DATA_W)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick_i),
    .mode_i     (mode_sel),
    .load_i     (tx_load_i),
    .data_i     (tx_data_i),
    .txd_o      (txd_o),
    .busy_o     (tx_busy),
    .done_o     (tx_done),
    .sclk_low_o (tx_sclk_low)
  );

  serport_rx #(.OVS(OVS), .DATA_W(DATA_W)) u_rx (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick_i),
    .mode_i      (mode_sel),
    .ren_i       (ren_i),
    .hold_i      (ri_o),
    .sm2_i       (sm2_i),
    .rxd_i       (rxd_i),
    .data_o      (rx_data_o),
    .done_o      (rx_done),
    .frame_end_o (rx_frame_end),
    .line_o      (rx_line),
    .busy_o      (rx_busy),
    .mode_o      (rx_mode),
    .sclk_low_o  (rx_sclk_low)
  );

  serport_flag u_ti (
    .clk    (clk),
    .rst    (rst),
    .set_i  (tx_done),
    .clr_i  (ti_clr_i),
    .flag_o (ti_o)
  );

  serport_flag u_ri (
    .clk    (clk),
    .rst    (rst),
    .set_i  (rx_done),
    .clr_i  (ri_clr_i),
    .flag_o (ri_o)
  );
endmodule

// File: rtl/serial_port_core_sva.sv
module serial_port_core_sva
  import serport_pkg::*;
(
  input logic     clk,
  input logic     rst,
  input logic     txd_o,
  input logic     sclk_o,
  input logic     ti_o,
  input logic     ri_o,
  input logic     ti_clr_i,
  input logic     ri_clr_i,
  input logic     sm2_i,
  input logic     tx_busy,
  input logic     rx_busy,
  input logic     rx_frame_end,
  input logic     rx_line,
  input sp_mode_e rx_mode
);
  AST_TI_AT_STOP_LEVEL: assert property (@(posedge clk) disable iff (rst)
    $rose(ti_o) |-> txd_o);  // R3

  AST_TXD_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> txd_o);  // R2

  AST_TI_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ti_o && !ti_clr_i) |=> ti_o);  // R10

  AST_RI_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ri_o && !ri_clr_i) |=> ri_o);  // R10

  AST_FILTER_BLOCKS_RI: assert property (@(posedge clk) disable iff (rst)
    (rx_frame_end && (rx_mode == MODE_FRAMED) && sm2_i && !rx_line && !ri_o)
      |=> !ri_o);  // R8

  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!tx_busy && !rx_busy) |-> sclk_o);  // R11
endmodule

bind serial_port_core serial_port_core_sva u_sva (
  .clk          (clk),
  .rst          (rst),
  .txd_o        (txd_o),
  .sclk_o       (sclk_o),
  .ti_o         (ti_o),
  .ri_o         (ri_o),
  .ti_clr_i     (ti_clr_i),
  .ri_clr_i     (ri_clr_i),
  .sm2_i        (sm2_i),
  .tx_busy      (tx_busy),
  .rx_busy      (rx_busy),
  .rx_frame_end (rx_frame_end),
  .rx_line      (rx_line),
  .rx_mode      (rx_mode)
);

// File: tb/serial_port_core_tb.sv
`timescale 1ns/1ps
module serial_port_core_tb;
  localparam int OVS = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b1;
  logic       mode = 1'b1;
  logic       sm2 = 1'b0;
  logic       ren = 1'b0;
  logic       load = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       ti_clr = 1'b0;
  logic       ri_clr = 1'b0;
  logic       loop = 1'b1;
  logic       rxd_drv = 1'b1;
  logic       txd, sclk, ti, ri;
  logic [7:0] rx_data;
  logic       rxd;

  int  checks = 0;
  int  errors = 0;
  int  cyc = 0;
  int  tick_div = 1;
  int  tick_cnt = 0;
  int  ri_cyc = -1;
  bit  mon_en = 1'b1;
  bit  done_flag = 1'b0;
  string mon_tag = "R6";
  logic [7:0] exp_q[$];

  assign rxd = loop ? txd : rxd_drv;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (tick_cnt >= tick_div - 1) begin
      tick <= 1'b1;
      tick_cnt <= 0;
    end else begin
      tick <= 1'b0;
      tick_cnt <= tick_cnt + 1;
    end
  end

  serial_port_core #(.OVS(OVS), .DATA_W(8)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick),
    .mode_i    (mode),
    .sm2_i     (sm2),
    .ren_i     (ren),
    .tx_load_i (load),
    .tx_data_i (tx_data),
    .rxd_i     (rxd),
    .ti_clr_i  (ti_clr),
    .ri_clr_i  (ri_clr),
    .txd_o     (txd),
    .sclk_o    (sclk),
    .rx_data_o (rx_data),
    .ti_o      (ti),
    .ri_o      (ri)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Scoreboard monitor: every RI must match the next expected byte.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && mon_en && ri) begin
        ri_cyc = cyc;
        if (exp_q.size() == 0) begin
          chk(1'b0, {mon_tag, " unexpected RI"}, rx_data, 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rx_data == e, mon_tag, rx_data, e);
        end
        ri_clr = 1'b1;
        @(negedge clk);
        ri_clr = 1'b0;
      end
    end
  end

  task automatic pulse_ti_clr();
    ti_clr = 1'b1;
    @(negedge clk);
    ti_clr = 1'b0;
  endtask

  // Cycle-exact transmit with loopback (tick every cycle).
  task automatic run_timed(input logic m, input logic [7:0] b, input bit intrude, input string btag);
    int base;
    int nbits;
    int ti_c;
    int ri_exp;
    logic [9:0] fr;
    nbits  = m ? 10 : 8;
    ti_c   = m ? 9*OVS : 8*OVS;
    ri_exp = m ? 3 + 9*OVS + OVS/2 : 8*OVS;
    fr     = m ? {1'b1, b, 1'b0} : {2'b11, b};
    mode = m;
    tx_data = b;
    load = 1'b1;
    if (!m) ren = 1'b1;
    exp_q.push_back(b);
    mon_tag = m ? "R6" : "R9";
    ri_cyc = -1;
    @(negedge clk);
    base = cyc;
    load = 1'b0;
    ren = 1'b0;
    for (int c = 1; c <= ti_c + OVS + 4; c++) begin
      if (intrude && c == 2*OVS) begin
        tx_data = 8'h0F;
        load = 1'b1;
      end else begin
        load = 1'b0;
      end
      @(negedge clk);
      if ((c % OVS) == OVS/2 && (c / OVS) < nbits)
        chk(txd == fr[c / OVS], btag, txd, fr[c / OVS]);
      if (!m && (c / OVS) < 8) begin
        if ((c % OVS) == OVS/4)   chk(sclk == 1'b0, "R11", sclk, 0);
        if ((c % OVS) == 3*OVS/4) chk(sclk == 1'b1, "R11", sclk, 1);
      end
      if (c == ti_c - 1) chk(ti == 1'b0, m ? "R3" : "R4", ti, 0);
      if (c == ti_c) begin
        chk(ti == 1'b1, m ? "R3" : "R4", ti, 1);
        chk(txd == 1'b1, m ? "R3" : "R4", txd, 1);
      end
    end
    load = 1'b0;
    chk(ti == 1'b1, "R10", ti, 1);
    pulse_ti_clr();
    chk(ti == 1'b0, "R10", ti, 0);
    chk(ri_cyc - base == ri_exp, m ? "R6" : "R9", ri_cyc - base, ri_exp);
    chk(exp_q.size() == 0, intrude ? "R5" : "R2", exp_q.size(), 0);
  endtask

  // Framed loopback with a slow tick: data only.
  task automatic run_loose(input logic [7:0] b);
    mode = 1'b1;
    tx_data = b;
    load = 1'b1;
    exp_q.push_back(b);
    mon_tag = "R2";
    @(negedge clk);
    load = 1'b0;
    for (int i = 0; i < 14*OVS*tick_div && exp_q.size() != 0; i++) @(negedge clk);
    repeat (2*OVS*tick_div) @(negedge clk);
    chk(exp_q.size() == 0, "R2", exp_q.size(), 0);
    chk(ti == 1'b1, "R3", ti, 1);
    pulse_ti_clr();
  endtask

  // Hand-driven framed frame on the receive line (tick every cycle).
  task automatic drive_frame(input logic [7:0] b, input logic stop);
    logic [9:0] fr;
    fr = {stop, b, 1'b0};
    loop = 1'b0;
    for (int k = 0; k < 10; k++) begin
      rxd_drv = fr[k];
      repeat (OVS) @(negedge clk);
    end
    rxd_drv = 1'b1;
    repeat (3*OVS) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(txd == 1'b1, "R1", txd, 1);
    chk(sclk == 1'b1, "R1", sclk, 1);
    chk(ti == 1'b0, "R1", ti, 0);
    chk(ri == 1'b0, "R1", ri, 0);
    chk(rx_data == 8'h00, "R1", rx_data, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1 && ti == 1'b0 && ri == 1'b0, "R1", {txd, ti, ri}, 3'b100);
    repeat (4) @(negedge clk);

    run_timed(1'b1, 8'hA5, 1'b0, "R2");
    repeat (OVS) @(negedge clk);
    run_timed(1'b1, 8'h3C, 1'b1, "R5");
    repeat (OVS) @(negedge clk);
    run_timed(1'b0, 8'h5A, 1'b0, "R4");
    repeat (OVS) @(negedge clk);
    run_timed(1'b0, 8'h81, 1'b0, "R4");
    mode = 1'b1;
    repeat (OVS) @(negedge clk);

    tick_div = 3;
    repeat (4) @(negedge clk);
    run_loose(8'h00);
    run_loose(8'hFF);
    run_loose(8'h96);
    tick_div = 1;
    repeat (4) @(negedge clk);

    // R7: short low glitch is discarded
    loop = 1'b0;
    rxd_drv = 1'b0;
    repeat (OVS/4) @(negedge clk);
    rxd_drv = 1'b1;
    repeat (12*OVS) @(negedge clk);
    chk(ri == 1'b0, "R7", ri, 0);
    chk(rx_data == 8'h96, "R7", rx_data, 8'h96);

    // R8: filter on, low stop bit
    sm2 = 1'b1;
    mon_tag = "R8";
    drive_frame(8'h4B, 1'b0);
    chk(ri == 1'b0, "R8", ri, 0);
    chk(rx_data == 8'h96, "R8", rx_data, 8'h96);
    // R8: filter off, same defect accepted
    sm2 = 1'b0;
    exp_q.push_back(8'h69);
    drive_frame(8'h69, 1'b0);
    chk(exp_q.size() == 0, "R8", exp_q.size(), 0);
    // filter on, good stop bit still accepted
    sm2 = 1'b1;
    exp_q.push_back(8'hC3);
    mon_tag = "R6";
    drive_frame(8'hC3, 1'b1);
    chk(exp_q.size() == 0, "R6", exp_q.size(), 0);
    sm2 = 1'b0;

    // R10: receive flag stays until cleared
    mon_en = 1'b0;
    @(negedge clk);
    drive_frame(8'h11, 1'b1);
    repeat (30) @(negedge clk);
    chk(ri == 1'b1, "R10", ri, 1);
    chk(rx_data == 8'h11, "R6", rx_data, 8'h11);
    ri_clr = 1'b1;
    @(negedge clk);
    ri_clr = 1'b0;
    chk(ri == 1'b0, "R10", ri, 0);
    repeat (5) @(negedge clk);
    chk(ri == 1'b0, "R10", ri, 0);
    mon_en = 1'b1;
    loop = 1'b1;

    repeat (10) @(negedge clk);
    done_flag = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule